// File: doc/BRIEF.md
# Receive FIFO with Trigger Flag

This block is the receive-side buffer of a serial audio peripheral. A serial receiver pushes words into a small FIFO, eight entries deep by default. A processor or a DMA engine drains it through a read strobe. Read data is registered and appears one cycle after the strobe. The current number of stored entries is always visible on a count output.

A sticky "receive data full" flag is compared against a trigger level. A 2-bit selector picks that level from the set 1, 2, 4 or 6. The flag rises whenever the stored count reaches the level. It falls only when the count has dropped below the level and one of two things happens: software writes a zero to the flag, or a DMA read empties the FIFO below the level while requests are enabled. The request output is the flag gated by an enable, and it is meant to feed an interrupt controller or a DMA channel.

Two error conditions are recorded in sticky bits that only reset clears. A push into a full FIFO is dropped and sets the overflow bit. A read from an empty FIFO leaves the data and the count untouched and sets the underflow bit.

Top module: `rx_trig_fifo`

## Requirements
- R1: Words are read out in the order they were pushed. The word consumed by an accepted read appears on `rd_data` in the cycle after the read strobe.
- R2: `fill_cnt` equals the number of stored entries and never exceeds DEPTH. An accepted push alone raises it by one, an accepted read alone lowers it by one, and both together leave it unchanged.
- R3: `trig_sel` selects the trigger level: code 2'b00 gives 1 entry, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 6.
- R4: The flag `rdf` is 1 in every cycle in which `fill_cnt` is at or above the selected trigger level.
- R5: A flag write with `flag_wr_val`=0 clears `rdf` only if the resulting count is below the trigger level. Such a write while the count is at or above the level leaves `rdf` at 1.
- R6: A flag write with `flag_wr_val`=1 never changes `rdf`.
- R7: An accepted read with `rd_dma`=1 while `req_en`=1 that leaves the count below the level clears `rdf` without a software write. A read with `rd_dma`=0 never clears `rdf`.
- R8: `req` is 1 exactly when `rdf`=1 and `req_en`=1.
- R9: After reset `fill_cnt`=0, `rdf`=0, `req`=0, `ovf`=0, `unf`=0 and `rd_data`=0.
- R10: A read while the FIFO is empty leaves `rd_data` and `fill_cnt` unchanged and sets `unf`. `unf` then stays 1 until reset.
- R11: A push while the FIFO holds DEPTH entries is discarded, so the stored data and the count are unchanged, and it sets `ovf`. `ovf` then stays 1 until reset.
- R12: Once `rdf` has been cleared, it rises again in the cycle after a push brings the count up to the trigger level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Receiver delivers a word this cycle |
| push_data | input | W | Word from the receiver |
| rd_en | input | 1 | Read strobe |
| rd_dma | input | 1 | The read comes from the DMA engine |
| rd_data | output | W | Last word read out |
| trig_sel | input | 2 | Trigger level code |
| req_en | input | 1 | Request enable |
| flag_wr_en | input | 1 | Software write to the flag |
| flag_wr_val | input | 1 | Value written to the flag |
| rdf | output | 1 | Receive data full flag |
| req | output | 1 | Interrupt / DMA request |
| fill_cnt | output | CW | Stored entry count |
| ovf | output | 1 | Sticky overflow |
| unf | output | 1 | Sticky underflow |

## Verification
The checker watches several properties on every cycle. It checks that the count stays bounded and steps by one on a lone push. It checks that the flag is always high at or above a stable level and can only fall when the count is below the previous level. It checks that a full push or an empty read leaves the count and data untouched, and that both error bits stay sticky. Other behaviours can only be shown by the bench's scenarios: the mapping of each trigger code to its level, the FIFO data order, and the outcome of software writes of zero and of one. So are the difference between DMA and processor reads, and the re-rise of the flag after a clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      TRIG_ONE   = 2'b00,
      TRIG_TWO   = 2'b01,
      TRIG_FOUR  = 2'b10,
      TRIG_SIX   = 2'b11
   } trig_code_e;

   localparam int MAX_LEVEL = 6;

   function automatic int level_of(input logic [1:0] code);
      case (trig_code_e'(code))
         TRIG_ONE:  return 1;
         TRIG_TWO:  return 2;
         TRIG_FOUR: return 4;
         default:   return 6;
      endcase
   endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] cnt_nxt,
   output logic          push_drop,
   output logic          pop_empty,
   output logic          pop_take
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

   logic [W-1:0]  slot [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          push_take;

   assign push_take = push && (cnt != FULL_CNT);
   assign push_drop = push && (cnt == FULL_CNT);
   assign pop_take  = pop && (cnt != '0);
   assign pop_empty = pop && (cnt == '0);
   assign cnt_nxt   = cnt + CW'(push_take) - CW'(pop_take);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_take && (wr_ptr == PW'(i)))
            slot[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         dout   <= '0;
      end else begin
         cnt <= cnt_nxt;
         if (push_take)
            wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         if (pop_take) begin
            dout   <= slot[rd_ptr];
            rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
   parameter int DEPTH     = 8,
   parameter bit REG_LEVEL = 1'b0,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    trig_sel,
   output logic [CW-1:0] lvl
);
   import rxf_pkg::*;

   logic [CW-1:0] lvl_dec;

   always_comb lvl_dec = CW'(level_of(trig_sel));

   if (REG_LEVEL) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl <= CW'(1);
         else        lvl <= lvl_dec;
      end
   end else begin : g_comb
      assign lvl = lvl_dec;
   end

endmodule

// File: rtl/rxf_flag.sv
module rxf_flag #(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_nxt,
   input  logic [CW-1:0] lvl,
   input  logic          wr_en,
   input  logic          wr_val,
   input  logic          dma_take,
   input  logic          req_en,
   input  logic          push_drop,
   input  logic          pop_empty,
   output logic          rdf,
   output logic          ovf,
   output logic          unf
);

   logic at_level, sw_zero, dma_drain, clr, rdf_nxt;

   assign at_level  = (cnt_nxt >= lvl);
   assign sw_zero   = wr_en && !wr_val;
   assign dma_drain = dma_take && req_en;
   assign clr       = sw_zero || dma_drain;
   assign rdf_nxt   = at_level || (rdf && !clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdf <= 1'b0;
         ovf <= 1'b0;
         unf <= 1'b0;
      end else begin
         rdf <= rdf_nxt;
         if (push_drop) ovf <= 1'b1;
         if (pop_empty) unf <= 1'b1;
      end
   end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
   parameter int W         = 16,
   parameter int DEPTH     = 8,
   parameter bit REG_LEVEL = 1'b0,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_valid,
   input  logic [W-1:0]  push_data,
   input  logic          rd_en,
   input  logic          rd_dma,
   output logic [W-1:0]  rd_data,
   input  logic [1:0]    trig_sel,
   input  logic          req_en,
   input  logic          flag_wr_en,
   input  logic          flag_wr_val,
   output logic          rdf,
   output logic          req,
   output logic [CW-1:0] fill_cnt,
   output logic          ovf,
   output logic          unf
);

   if (DEPTH < rxf_pkg::MAX_LEVEL) begin : g_bad_depth
      $error("rx_trig_fifo: DEPTH must be at least the largest trigger level");
   end
   if (W < 1) begin : g_bad_width
      $error("rx_trig_fifo: W must be positive");
   end

   logic [CW-1:0] cnt_nxt;
   logic [CW-1:0] lvl;
   logic          push_drop, pop_empty, pop_take;

   rxf_store #(.W(W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_valid),
      .din       (push_data),
      .pop       (rd_en),
      .dout      (rd_data),
      .cnt       (fill_cnt),
      .cnt_nxt   (cnt_nxt),
      .push_drop (push_drop),
      .pop_empty (pop_empty),
      .pop_take  (pop_take)
   );

   rxf_level #(.DEPTH(DEPTH), .REG_LEVEL(REG_LEVEL)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_sel (trig_sel),
      .lvl      (lvl)
   );

   rxf_flag #(.DEPTH(DEPTH)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_nxt   (cnt_nxt),
      .lvl       (lvl),
      .wr_en     (flag_wr_en),
      .wr_val    (flag_wr_val),
      .dma_take  (pop_take && rd_dma),
      .req_en    (req_en),
      .push_drop (push_drop),
      .pop_empty (pop_empty),
      .rdf       (rdf),
      .ovf       (ovf),
      .unf       (unf)
   );

   assign req = rdf && req_en;

endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          push_valid,
   input logic          rd_en,
   input logic [W-1:0]  rd_data,
   input logic          rdf,
   input logic [CW-1:0] fill_cnt,
   input logic [CW-1:0] lvl,
   input logic          ovf,
   input logic          unf
);

   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CW'(DEPTH));

   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !rd_en && fill_cnt < CW'(DEPTH)) |=> fill_cnt == $past(fill_cnt) + 1'b1);

   assert_flag_at_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(lvl) && fill_cnt >= lvl) |-> rdf);

   assert_fall_below_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdf) |-> fill_cnt < $past(lvl));

   assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !push_valid && fill_cnt == '0) |=> ($stable(rd_data) && fill_cnt == '0 && unf));

   assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !rd_en && fill_cnt == CW'(DEPTH)) |=> (fill_cnt == CW'(DEPTH) && ovf));

   assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

endmodule

bind rx_trig_fifo rxf_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_valid (push_valid),
   .rd_en      (rd_en),
   .rd_data    (rd_data),
   .rdf        (rdf),
   .fill_cnt   (fill_cnt),
   .lvl        (lvl),
   .ovf        (ovf),
   .unf        (unf)
);

// File: tb/sim_rx_trig_fifo.sv
module sim_rx_trig_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 16;
   localparam int DEPTH = 8;
   localparam int CW = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_valid = 1'b0;
   logic [W-1:0]  push_data = '0;
   logic          rd_en = 1'b0;
   logic          rd_dma = 1'b0;
   logic [W-1:0]  rd_data;
   logic [1:0]    trig_sel = 2'b00;
   logic          req_en = 1'b0;
   logic          flag_wr_en = 1'b0;
   logic          flag_wr_val = 1'b0;
   logic          rdf, req, ovf, unf;
   logic [CW-1:0] fill_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_trig_fifo #(.W(W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .rd_en(rd_en), .rd_dma(rd_dma), .rd_data(rd_data), .trig_sel(trig_sel),
      .req_en(req_en), .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val),
      .rdf(rdf), .req(req), .fill_cnt(fill_cnt), .ovf(ovf), .unf(unf)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
      push_valid = 0; rd_en = 0; rd_dma = 0; flag_wr_en = 0; flag_wr_val = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; push_valid = 0; rd_en = 0; rd_dma = 0;
      flag_wr_en = 0; req_en = 0; trig_sel = 2'b00;
      @(posedge clk); #1; rst_n = 1;
   endtask

   task automatic push(input int v);
      push_valid = 1; push_data = W'(v); tick();
   endtask

   task automatic pop(input bit dma);
      rd_en = 1; rd_dma = dma; tick();
   endtask

   task automatic flag_write(input bit v);
      flag_wr_en = 1; flag_wr_val = v; tick();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R9 fill_cnt", int'(fill_cnt), 0);
      chk("R9 rdf", int'(rdf), 0);
      chk("R9 req", int'(req), 0);
      chk("R9 ovf", int'(ovf), 0);
      chk("R9 unf", int'(unf), 0);
      chk("R9 rd_data", int'(rd_data), 0);
   endtask

   task automatic t_order();
      do_reset(); trig_sel = 2'b11;
      push(16'h11); push(16'h22); push(16'h33);
      chk("R2 count after 3 pushes", int'(fill_cnt), 3);
      pop(0); chk("R1 first word", int'(rd_data), 16'h11);
      chk("R2 count after read", int'(fill_cnt), 2);
      push_valid = 1; push_data = 16'h44; rd_en = 1; tick();
      chk("R1 word during push+read", int'(rd_data), 16'h22);
      chk("R2 count push+read", int'(fill_cnt), 2);
      pop(0); chk("R1 third word", int'(rd_data), 16'h33);
      pop(0); chk("R1 fourth word", int'(rd_data), 16'h44);
   endtask

   task automatic t_levels();
      for (int c = 0; c < 4; c++) begin
         int lv;
         lv = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : 6;
         do_reset(); trig_sel = 2'(c);
         for (int k = 0; k < lv - 1; k++) push(k);
         chk($sformatf("R3 code %0d below level", c), int'(rdf), 0);
         push(99);
         chk($sformatf("R4 code %0d at level", c), int'(rdf), 1);
      end
   endtask

   task automatic t_swclear();
      do_reset(); trig_sel = 2'b01;
      push(1); push(2); push(3);
      chk("R4 flag set", int'(rdf), 1);
      flag_write(1); chk("R6 write one keeps flag", int'(rdf), 1);
      flag_write(0); chk("R5 zero above level ignored", int'(rdf), 1);
      pop(0); pop(0);
      chk("R7 cpu read does not clear", int'(rdf), 1);
      flag_write(1); chk("R6 write one below level no clear", int'(rdf), 1);
      flag_write(0); chk("R5 zero below level clears", int'(rdf), 0);
      flag_write(1); chk("R6 write one does not set", int'(rdf), 0);
   endtask

   task automatic t_dma();
      do_reset(); trig_sel = 2'b10; req_en = 1;
      push(1); push(2); push(3); push(4);
      chk("R8 req high", int'(req), 1);
      req_en = 0; #1; chk("R8 req gated", int'(req), 0);
      chk("R8 flag stays while gated", int'(rdf), 1);
      req_en = 1;
      pop(1);
      chk("R7 dma read clears", int'(rdf), 0);
      chk("R8 req low after clear", int'(req), 0);
      push(5);
      chk("R12 reassert on reaching level", int'(rdf), 1);
   endtask

   task automatic t_underflow();
      do_reset(); trig_sel = 2'b11;
      push(16'hAB); pop(0);
      chk("R1 read word", int'(rd_data), 16'hAB);
      pop(0);
      chk("R10 data held", int'(rd_data), 16'hAB);
      chk("R10 count held", int'(fill_cnt), 0);
      chk("R10 unf set", int'(unf), 1);
      tick(); chk("R10 unf sticky", int'(unf), 1);
   endtask

   task automatic t_overflow();
      do_reset(); trig_sel = 2'b11;
      for (int k = 0; k < DEPTH + 1; k++) push(16'h100 + k);
      chk("R11 count full", int'(fill_cnt), DEPTH);
      chk("R11 ovf set", int'(ovf), 1);
      for (int k = 0; k < DEPTH; k++) begin
         pop(0);
         chk("R11 stored data kept", int'(rd_data), 16'h100 + k);
      end
      chk("R11 ovf sticky", int'(ovf), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_order();
      t_levels();
      t_swclear();
      t_dma();
      t_underflow();
      t_overflow();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule